// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns one of several free-running clock-enable sources into the two timing pulses a UART channel needs: a sample tick at the oversampling rate and a bit strobe at each bit boundary. A 2-bit field picks the source, and a second 2-bit field divides it by 1, 2, 4 or 8 to form the operating clock enable. Every clock edge where that enable is high is one operating cycle. The sample counter divides the operating cycles by an 8-bit base divisor plus one. A bit holds either 16 or 4 sample ticks. After the last sample tick of a bit, a 4-bit fine-adjust count of extra operating cycles is added as a stall. This allows baud rates that a pure product of divisors cannot reach.

The receive logic pulses a synchronous restart on a start-bit edge, so the first bit period is measured from that edge. Divisor, ratio and fine-adjust values are captured into shadow state only at a restart or at a bit boundary. A change in the middle of a bit therefore never shortens or stretches the bit in progress.

A debug-halt input with a debug-run enable models clock gating while the CPU is halted. With debug-run low, the operating clock is withheld and every counter holds its value. With debug-run high, counting continues.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both `sample_tick` and `bit_strobe` are low.
- R2: With fine-adjust 0, consecutive sample ticks are exactly (base_div+1) operating cycles apart.
- R3: `os_quarter`=0 gives 16 sample ticks per bit and `os_quarter`=1 gives 4. Counting in (strobe, next strobe], exactly that many ticks occur.
- R4: Clock edges between consecutive bit strobes equal ((base_div+1)×ratio + fine_adj) × operating-cycle spacing. The fine-adjust cycles follow the last sample tick of the bit, so `bit_strobe` coincides with the last sample tick only when fine_adj is 0.
- R5: `src_sel` picks bit `src_sel` of `src_tick` as the source. `prediv_sel` value s makes one operating cycle out of every 2^s source ticks.
- R6: While `dbg_halt`=1 and `dbg_run`=0, no operating cycle occurs and no pulses are issued. Every counter holds its value, so each halted clock edge delays the next bit strobe by exactly one edge.
- R7: While `dbg_halt`=1 and `dbg_run`=1, timing is identical to `dbg_halt`=0.
- R8: A change of base_div, os_quarter or fine_adj takes effect from the first bit that starts after the next bit strobe. The bit in progress keeps the old values.
- R9: A `restart` pulse clears every counter and loads the configuration. With prediv 1 and an always-high source, the first bit strobe comes exactly one bit period after the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Candidate clock-enable sources |
| src_sel | input | 2 | Source select |
| prediv_sel | input | 2 | Pre-divider select, divide by 2^value |
| os_quarter | input | 1 | 1: 4 samples per bit, 0: 16 samples per bit |
| base_div | input | 8 | Base divisor; sample period is value+1 operating cycles |
| fine_adj | input | 4 | Extra operating cycles per bit |
| restart | input | 1 | Synchronous counter clear and configuration load |
| dbg_halt | input | 1 | CPU is in debug state |
| dbg_run | input | 1 | Keep counting while in debug state |
| sample_tick | output | 1 | One-clock oversampling pulse |
| bit_strobe | output | 1 | One-clock bit-boundary pulse |

## Verification
The assertions assume that `restart` lasts a single clock and is not raised during a debug halt with `dbg_run` low. They also assume that `prediv_sel` changes only at a restart, so the relation between operating cycles and clock edges stays fixed within a bit. The stimulus meets these assumptions: every configuration, including the pre-divider, is set at a falling edge before a one-cycle restart. The only mid-bit change is to the base divisor, which R8 exercises, and debug windows are opened well after the restart.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_W     = 8;
    localparam int FINE_W    = 4;
    localparam int OS_HI     = 16;
    localparam int OS_LO     = 4;
    localparam int SMP_W     = $clog2(OS_HI);
    localparam int SRC_N     = 4;
    localparam int SRC_SEL_W = $clog2(SRC_N);
    localparam int PRE_SEL_W = 2;
    localparam int PRE_CNT_W = (1 << PRE_SEL_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              quarter;
        logic [FINE_W-1:0] fine;
    } baud_cfg_t;
endpackage

// File: rtl/baud_opclk.sv
module baud_opclk
    import baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     src_tick,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic [PRE_SEL_W-1:0] prediv_sel,
    input  logic                 restart,
    input  logic                 dbg_halt,
    input  logic                 dbg_run,
    output logic                 op_en
);
    typedef struct packed {
        logic [PRE_CNT_W-1:0] pre_cnt;
    } opclk_st_t;

    opclk_st_t st_d, st_q;
    logic                 supplied;
    logic                 src_now;
    logic [PRE_CNT_W-1:0] mask;

    always_comb begin
        st_d     = st_q;
        op_en    = 1'b0;
        supplied = !(dbg_halt && !dbg_run);
        src_now  = src_tick[src_sel];
        mask     = PRE_CNT_W'((1 << prediv_sel) - 1);
        if (restart) begin
            st_d.pre_cnt = '0;
        end else if (supplied && src_now) begin
            if ((st_q.pre_cnt & mask) == mask) begin
                op_en        = 1'b1;
                st_d.pre_cnt = '0;
            end else begin
                st_d.pre_cnt = st_q.pre_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_hold_in_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !dbg_run && !restart) |=> $stable(st_q.pre_cnt));

    p_prediv_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && prediv_sel != '0) |=> (!op_en || prediv_sel == '0));
endmodule

// File: rtl/baud_sampler.sv
module baud_sampler
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_en,
    input  logic      restart,
    input  baud_cfg_t cfg_in,
    output logic      sample_tick,
    output logic      bit_strobe
);
    typedef struct packed {
        logic [DIV_W-1:0]  div_cnt;
        logic [SMP_W-1:0]  smp_cnt;
        logic [FINE_W-1:0] stl_cnt;
        logic              stalling;
        baud_cfg_t         cfg;
        logic              smp;
        logic              bit_end;
    } smp_st_t;

    smp_st_t st_d, st_q;
    logic [SMP_W-1:0] last_smp;

    always_comb begin
        st_d         = st_q;
        st_d.smp     = 1'b0;
        st_d.bit_end = 1'b0;
        last_smp     = st_q.cfg.quarter ? SMP_W'(OS_LO - 1) : SMP_W'(OS_HI - 1);
        if (restart) begin
            st_d.div_cnt  = '0;
            st_d.smp_cnt  = '0;
            st_d.stl_cnt  = '0;
            st_d.stalling = 1'b0;
            st_d.cfg      = cfg_in;
        end else if (op_en) begin
            if (st_q.stalling) begin
                if (st_q.stl_cnt == st_q.cfg.fine - 1'b1) begin
                    st_d.stalling = 1'b0;
                    st_d.stl_cnt  = '0;
                    st_d.bit_end  = 1'b1;
                    st_d.cfg      = cfg_in;
                end else begin
                    st_d.stl_cnt = st_q.stl_cnt + 1'b1;
                end
            end else if (st_q.div_cnt == st_q.cfg.div) begin
                st_d.div_cnt = '0;
                st_d.smp     = 1'b1;
                if (st_q.smp_cnt == last_smp) begin
                    st_d.smp_cnt = '0;
                    if (st_q.cfg.fine == '0) begin
                        st_d.bit_end = 1'b1;
                        st_d.cfg     = cfg_in;
                    end else begin
                        st_d.stalling = 1'b1;
                    end
                end else begin
                    st_d.smp_cnt = st_q.smp_cnt + 1'b1;
                end
            end else begin
                st_d.div_cnt = st_q.div_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_tick = st_q.smp;
    assign bit_strobe  = st_q.bit_end;

    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div_cnt <= st_q.cfg.div);

    p_smp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.smp_cnt <= (st_q.cfg.quarter ? SMP_W'(OS_LO - 1) : SMP_W'(OS_HI - 1)));

    p_strobe_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (st_q.div_cnt == '0 && st_q.smp_cnt == '0 && !st_q.stalling));

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en && !restart) |=> ($stable(st_q.div_cnt) && $stable(st_q.smp_cnt)
                                  && $stable(st_q.stl_cnt) && $stable(st_q.stalling)));

    p_cfg_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cfg) |-> (bit_strobe || $past(restart)));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     src_tick,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic [PRE_SEL_W-1:0] prediv_sel,
    input  logic                 os_quarter,
    input  logic [DIV_W-1:0]     base_div,
    input  logic [FINE_W-1:0]    fine_adj,
    input  logic                 restart,
    input  logic                 dbg_halt,
    input  logic                 dbg_run,
    output logic                 sample_tick,
    output logic                 bit_strobe
);
    logic      op_en;
    baud_cfg_t cfg_in;

    assign cfg_in = '{div: base_div, quarter: os_quarter, fine: fine_adj};

    baud_opclk u_opclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick   (src_tick),
        .src_sel    (src_sel),
        .prediv_sel (prediv_sel),
        .restart    (restart),
        .dbg_halt   (dbg_halt),
        .dbg_run    (dbg_run),
        .op_en      (op_en)
    );

    baud_sampler u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_en       (op_en),
        .restart     (restart),
        .cfg_in      (cfg_in),
        .sample_tick (sample_tick),
        .bit_strobe  (bit_strobe)
    );

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!sample_tick && !bit_strobe));
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick;
    logic [1:0] src_sel = '0;
    logic [1:0] prediv_sel = '0;
    logic       os_quarter = 1'b0;
    logic [7:0] base_div = '0;
    logic [3:0] fine_adj = '0;
    logic       restart = 1'b0;
    logic       dbg_halt = 1'b0;
    logic       dbg_run = 1'b0;
    logic       sample_tick, bit_strobe;
    logic       alt = 1'b0;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        alt <= ~alt;
    end
    assign src_tick = {1'b0, 1'b0, alt, 1'b1};

    baud_tick_gen u0 (.*);

    // {src_sel, prediv_sel, os_quarter, base_div, fine_adj, expected clocks per bit}
    localparam logic [28:0] VEC [8] = '{
        {2'd0, 2'd0, 1'b0, 8'd0,   4'd0,  12'd16},
        {2'd0, 2'd0, 1'b1, 8'd2,   4'd0,  12'd12},
        {2'd0, 2'd0, 1'b0, 8'd3,   4'd5,  12'd69},
        {2'd0, 2'd0, 1'b1, 8'd0,   4'd15, 12'd19},
        {2'd0, 2'd1, 1'b1, 8'd1,   4'd3,  12'd22},
        {2'd1, 2'd0, 1'b1, 8'd1,   4'd1,  12'd18},
        {2'd0, 2'd2, 1'b1, 8'd0,   4'd0,  12'd16},
        {2'd0, 2'd0, 1'b1, 8'd255, 4'd2,  12'd1026}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_restart(output int t);
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        t = cyc;
    endtask

    task automatic wait_strobe(output int t, output int ticks);
        ticks = 0;
        do begin
            @(negedge clk);
            if (sample_tick) ticks++;
        end while (!bit_strobe);
        t = cyc;
    endtask

    task automatic wait_tick(output int t);
        do @(negedge clk); while (!sample_tick);
        t = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t0, t1, t2, n, dummy;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sample_tick in reset", int'(sample_tick), 0);
        check("R1 bit_strobe in reset", int'(bit_strobe), 0);
        @(negedge clk) rst_n = 1'b1;

        // Table: R3, R4, R5, R9
        for (int i = 0; i < 8; i++) begin
            src_sel    = VEC[i][28:27];
            prediv_sel = VEC[i][26:25];
            os_quarter = VEC[i][24];
            base_div   = VEC[i][23:16];
            fine_adj   = VEC[i][15:12];
            do_restart(t0);
            wait_strobe(t1, dummy);
            if (VEC[i][28:27] == 2'd0)
                check("R9 restart to first strobe", t1 - t0,
                      int'(VEC[i][11:0]));
            wait_strobe(t2, n);
            check("R4/R5 clocks per bit", t2 - t1, int'(VEC[i][11:0]));
            check("R3 samples per bit", n, VEC[i][24] ? 4 : 16);
        end

        // R2: sample spacing, fine 0
        src_sel = 2'd0; prediv_sel = 2'd0; os_quarter = 1'b0;
        base_div = 8'd5; fine_adj = 4'd0;
        do_restart(t0);
        wait_tick(t1);
        check("R2 first sample tick", t1 - t0, 6);
        wait_tick(t2);
        check("R2 sample spacing", t2 - t1, 6);

        // R4: strobe not on last sample when fine nonzero
        os_quarter = 1'b1; base_div = 8'd1; fine_adj = 4'd3;
        do_restart(t0);
        wait_strobe(t1, dummy);
        check("R4 no sample with stalled strobe", int'(sample_tick), 0);

        // R6: debug halt with dbg_run=0 freezes (16 + 7)
        os_quarter = 1'b1; base_div = 8'd3; fine_adj = 4'd0; dbg_run = 1'b0;
        do_restart(t0);
        repeat (4) @(negedge clk);
        dbg_halt = 1'b1;
        n = 0;
        repeat (7) begin
            @(negedge clk);
            if (sample_tick || bit_strobe) n++;
        end
        dbg_halt = 1'b0;
        check("R6 pulses during halt", n, 0);
        wait_strobe(t1, dummy);
        check("R6 frozen delay", t1 - t0, 23);

        // R7: dbg_run=1 continues
        dbg_run = 1'b1;
        do_restart(t0);
        repeat (4) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (7) @(negedge clk);
        dbg_halt = 1'b0;
        wait_strobe(t1, dummy);
        check("R7 run during debug", t1 - t0, 16);
        dbg_run = 1'b0;

        // R8: mid-bit divisor change applies at next bit
        base_div = 8'd3;
        do_restart(t0);
        repeat (3) @(negedge clk);
        base_div = 8'd1;
        wait_strobe(t1, dummy);
        check("R8 current bit keeps old", t1 - t0, 16);
        wait_strobe(t2, dummy);
        check("R8 next bit uses new", t2 - t1, 8);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule